// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block is a parameterised N-way set-associative data cache that sits between a processor port issuing 32-bit word reads and writes and a word-wide memory port. It splits each address into a word offset, a set index and a tag. It looks the tag up in the ways of the selected set. A hit is served from local storage. A miss is served by fetching the whole line from memory, after first writing back the victim line when that is needed.

The write behaviour is picked at run time from three policies: write-back, write-through with allocation, and write-through without allocation. Addresses from 0xF0000000 upward, and every access while the cache is disabled, skip the cache and make a single memory transfer. A flush command writes back every dirty valid line and empties the cache. An invalidate command empties it at once and writes nothing back. A small replacement unit picks the victim way through a request/response pair.

Top module: `assoc_cache`

## Requirements
- R1: When `cache_en` is low, or the address is at or above 0xF0000000, an access makes exactly one memory transfer at the request address with the request direction. A read returns the memory word. The line storage is left unchanged.
- R2: Address fields: the word offset is bits [2 +: log2(WORDS)], the set index is the next log2(SETS) bits, and the tag is the remaining upper bits. With the default parameters these are [3:2], [5:4] and [31:6]. A line fill reads the line's words in ascending order from base+0 to base+4*(WORDS-1). The base is the address with its offset and byte bits cleared.
- R3: A read hit returns the stored word with no memory traffic. The hit is the lowest-numbered way in the set that is valid and has a matching tag.
- R4: A read miss fills the line into the victim way and then returns the requested word.
- R5: Policy encoding on `wr_policy`: 0 is write-back, 1 is write-through with allocation, 2 is write-through without allocation, and 3 acts as 1. Under write-back, a write hit causes no memory traffic and marks the line dirty. Evicting a dirty line writes all of its words back in ascending order from the evicted line's base, before the fill begins.
- R6: Under either write-through policy, every cached write (hit, or allocating miss after its fill) makes one memory write with the request address and data.
- R7: Under write-through without allocation, a write miss makes one memory write and no fill, so a later read of that address still misses.
- R8: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim comes from a per-set rotating pointer that starts at way 0 and steps by one on each such eviction.
- R9: A flush visits ways from the highest index down to 0, and within each way visits sets in ascending order. Under write-back it writes back each dirty valid line. It leaves every line invalid.
- R10: An invalidate clears every line in one cycle with no memory traffic. Data held only in dirty lines is lost.
- R11: `cpu_busy` is low after reset. It goes high in the cycle after a request is accepted and stays high until the cycle in which `cpu_done` pulses for one cycle. Requests are taken only while `cpu_busy` is low. `mem_req` keeps its address, direction and data stable until `mem_ack`.
- R12: Replacing a clean valid line, or any line under a write-through policy, writes nothing back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Cache enable; when low, every access bypasses the cache |
| wr_policy | input | 2 | Write policy; held stable while busy |
| cpu_req | input | 1 | Access request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Controller is working on a request or command |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with `cpu_done` |
| flush_req | input | 1 | Start a flush (taken when idle) |
| inval_req | input | 1 | Invalidate all lines (taken when idle, highest priority) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench keeps its own model of tags, valid and dirty bits and victim pointers. It predicts the exact ordered list of memory transfers for every access, flush and invalidate, so a design that fills words out of order, writes back a clean line, or evicts from the wrong way shows up as a traffic mismatch. Random traffic over four tags and four sets drives full sets and so exercises pointer rotation. A design that advanced the pointer when an invalid way was still free would evict the wrong line. Write-back data lost on eviction, or a stale write-through value, is caught by comparing memory against the architectural value of every written word after each flush. A directed write miss followed by a read under no-allocate exposes a design that allocates anyway. A directed invalidate after a dirty write exposes a design that writes back on invalidate.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

    localparam logic [31:0] UNCACHED_BASE = 32'hF000_0000;

    localparam logic [1:0] POL_WBACK      = 2'd0;
    localparam logic [1:0] POL_WT_NOALLOC = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU,
        ST_BYPASS,
        ST_FLUSH
    } ctl_state_e;

endpackage

// File: rtl/assoc_cache_store.sv
module assoc_cache_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int WORDS = 4,
    parameter int TAG_W = 26
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(SETS)-1:0]              look_set,
    output logic [WAYS-1:0]                      valid_o,
    output logic [WAYS-1:0]                      dirty_o,
    output logic [WAYS-1:0][TAG_W-1:0]           tag_o,
    input  logic [$clog2(WAYS)-1:0]              rd_way,
    input  logic [$clog2(WORDS)-1:0]             rd_word,
    output logic [31:0]                          rd_data,
    input  logic [$clog2(WAYS)-1:0]              op_way,
    input  logic                                 wr_en,
    input  logic [$clog2(WORDS)-1:0]             wr_word,
    input  logic [31:0]                          wr_data,
    input  logic                                 wr_dirty,
    input  logic                                 inst_en,
    input  logic [TAG_W-1:0]                     inst_tag,
    input  logic                                 inv_en,
    input  logic                                 clr_all
);

    typedef struct packed {
        logic [WAYS-1:0][SETS-1:0]                   valid;
        logic [WAYS-1:0][SETS-1:0]                   dirty;
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]        tag;
        logic [WAYS-1:0][SETS-1:0][WORDS-1:0][31:0]  data;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_all) begin
            s_d.valid = '0;
            s_d.dirty = '0;
        end else begin
            if (wr_en) begin
                s_d.data[op_way][look_set][wr_word] = wr_data;
                if (wr_dirty) s_d.dirty[op_way][look_set] = 1'b1;
            end
            if (inst_en) begin
                s_d.valid[op_way][look_set] = 1'b1;
                s_d.dirty[op_way][look_set] = 1'b0;
                s_d.tag[op_way][look_set]   = inst_tag;
            end
            if (inv_en) begin
                s_d.valid[op_way][look_set] = 1'b0;
                s_d.dirty[op_way][look_set] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way_out
        assign valid_o[w] = s_q.valid[w][look_set];
        assign dirty_o[w] = s_q.dirty[w][look_set];
        assign tag_o[w]   = s_q.tag[w][look_set];
    end

    assign rd_data = s_q.data[rd_way][look_set][rd_word];

    // A line made valid by an install is valid on the next cycle (R4)
    assert_install_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_en && !clr_all && !inv_en) |=> s_q.valid[$past(op_way)][$past(look_set)]);

    // After a clear nothing is valid (R10)
    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (s_q.valid == '0));

endmodule

// File: rtl/assoc_cache_victim.sv
module assoc_cache_victim #(
    parameter int WAYS = 2,
    parameter int SETS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vic_req,
    input  logic [$clog2(SETS)-1:0]     vic_set,
    input  logic [WAYS-1:0]             vic_valid,
    output logic [$clog2(WAYS)-1:0]     vic_way
);

    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAY_W-1:0] ptr_d, ptr_q;

    always_comb begin
        vic_way = ptr_q[vic_set];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vic_valid[w]) vic_way = WAY_W'(w);
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (vic_req && (&vic_valid)) begin
            if (ptr_q[vic_set] == WAY_W'(WAYS - 1)) ptr_d[vic_set] = '0;
            else                                     ptr_d[vic_set] = ptr_q[vic_set] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // A free way is always taken before a valid one (R8)
    assert_free_way_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && !(&vic_valid)) |-> !vic_valid[vic_way]);

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import assoc_cache_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cache_en,
    input  logic [1:0]  wr_policy,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_busy,
    output logic        cpu_done,
    output logic [31:0] cpu_rdata,
    input  logic        flush_req,
    input  logic        inval_req,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);

    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = $clog2(SETS);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int SET_LSB = 2 + OFF_W;
    localparam int TAG_LSB = SET_LSB + SET_W;
    localparam int TAG_W   = 32 - TAG_LSB;

    typedef struct packed {
        ctl_state_e        state;
        logic              we;
        logic [31:0]       addr;
        logic [31:0]       wdata;
        logic [WAY_W-1:0]  way;
        logic [SET_W-1:0]  fset;
        logic [OFF_W-1:0]  cnt;
        logic              flushing;
        logic              done;
        logic [31:0]       rdata;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic [TAG_W-1:0] req_tag;
    logic [SET_W-1:0] req_set;
    logic [OFF_W-1:0] req_word;
    logic [SET_W-1:0] cur_set;
    logic             pol_wb, pol_noalloc;

    assign req_tag     = r_q.addr[31:TAG_LSB];
    assign req_set     = r_q.addr[SET_LSB +: SET_W];
    assign req_word    = r_q.addr[2 +: OFF_W];
    assign cur_set     = (r_q.state == ST_FLUSH || r_q.flushing) ? r_q.fset : req_set;
    assign pol_wb      = (wr_policy == POL_WBACK);
    assign pol_noalloc = (wr_policy == POL_WT_NOALLOC);

    // storage interface
    logic [WAYS-1:0]             valid_v, dirty_v;
    logic [WAYS-1:0][TAG_W-1:0]  tag_v;
    logic [WAY_W-1:0]            rd_way, op_way;
    logic [OFF_W-1:0]            rd_word, wr_word;
    logic [31:0]                 rd_data, wr_data;
    logic                        wr_en, wr_dirty, inst_en, inv_en, clr_all;

    // victim interface
    logic                        vic_req;
    logic [WAY_W-1:0]            vic_way;

    assoc_cache_store #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_set (cur_set),
        .valid_o  (valid_v),
        .dirty_o  (dirty_v),
        .tag_o    (tag_v),
        .rd_way   (rd_way),
        .rd_word  (rd_word),
        .rd_data  (rd_data),
        .op_way   (op_way),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .inst_en  (inst_en),
        .inst_tag (req_tag),
        .inv_en   (inv_en),
        .clr_all  (clr_all)
    );

    assoc_cache_victim #(
        .WAYS(WAYS), .SETS(SETS)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .vic_req   (vic_req),
        .vic_set   (req_set),
        .vic_valid (valid_v),
        .vic_way   (vic_way)
    );

    // hit search: lowest-numbered matching way wins
    logic             hit;
    logic [WAY_W-1:0] hit_way;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_v[w] && (tag_v[w] == req_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // flush walk: sets ascending inside a way, ways descending
    logic             fl_last, fl_set_wrap;
    logic [SET_W-1:0] fl_next_set;
    logic [WAY_W-1:0] fl_next_way;

    assign fl_set_wrap = (r_q.fset == SET_W'(SETS - 1));
    assign fl_last     = fl_set_wrap && (r_q.way == '0);
    assign fl_next_set = fl_set_wrap ? '0 : r_q.fset + 1'b1;
    assign fl_next_way = fl_set_wrap ? r_q.way - 1'b1 : r_q.way;

    logic last_word;
    assign last_word = (r_q.cnt == OFF_W'(WORDS - 1));

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        rd_way     = r_q.way;
        rd_word    = r_q.cnt;
        op_way     = r_q.way;
        wr_word    = r_q.cnt;
        wr_data    = mem_rdata;
        wr_en      = 1'b0;
        wr_dirty   = 1'b0;
        inst_en    = 1'b0;
        inv_en     = 1'b0;
        clr_all    = 1'b0;
        vic_req    = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (inval_req) begin
                    clr_all = 1'b1;
                end else if (flush_req) begin
                    r_d.way   = WAY_W'(WAYS - 1);
                    r_d.fset  = '0;
                    r_d.state = ST_FLUSH;
                end else if (cpu_req) begin
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    r_d.cnt   = '0;
                    if (!cache_en || cpu_addr >= UNCACHED_BASE) r_d.state = ST_BYPASS;
                    else                                        r_d.state = ST_LOOKUP;
                end
            end

            ST_LOOKUP: begin
                rd_way  = hit_way;
                rd_word = req_word;
                if (hit) begin
                    if (!r_q.we) begin
                        r_d.rdata = rd_data;
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        op_way   = hit_way;
                        wr_word  = req_word;
                        wr_data  = r_q.wdata;
                        wr_en    = 1'b1;
                        wr_dirty = 1'b1;
                        if (pol_wb) begin
                            r_d.done  = 1'b1;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.state = ST_WTHRU;
                        end
                    end
                end else if (r_q.we && pol_noalloc) begin
                    r_d.state = ST_WTHRU;
                end else begin
                    vic_req = 1'b1;
                    op_way  = vic_way;
                    r_d.way = vic_way;
                    r_d.cnt = '0;
                    if (valid_v[vic_way] && dirty_v[vic_way] && pol_wb) begin
                        r_d.state = ST_WBACK;
                    end else begin
                        inv_en    = valid_v[vic_way];
                        r_d.state = ST_FILL;
                    end
                end
            end

            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_v[r_q.way], cur_set, r_q.cnt, 2'b00};
                mem_wdata = rd_data;
                if (mem_ack) begin
                    if (last_word) begin
                        inv_en       = 1'b1;
                        r_d.cnt      = '0;
                        r_d.flushing = 1'b0;
                        if (r_q.flushing) begin
                            r_d.fset  = fl_next_set;
                            r_d.way   = fl_next_way;
                            r_d.state = fl_last ? ST_IDLE : ST_FLUSH;
                        end else begin
                            r_d.state = ST_FILL;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end

            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_set, r_q.cnt, 2'b00};
                if (mem_ack) begin
                    wr_en = 1'b1;
                    if (last_word) begin
                        inst_en   = 1'b1;
                        r_d.cnt   = '0;
                        r_d.state = ST_LOOKUP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end

            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.addr;
                mem_wdata = r_q.wdata;
                if (mem_ack) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end

            ST_BYPASS: begin
                mem_req   = 1'b1;
                mem_we    = r_q.we;
                mem_addr  = r_q.addr;
                mem_wdata = r_q.we ? r_q.wdata : 32'h0;
                if (mem_ack) begin
                    r_d.rdata = mem_rdata;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end

            ST_FLUSH: begin
                if (valid_v[r_q.way] && dirty_v[r_q.way] && pol_wb) begin
                    r_d.flushing = 1'b1;
                    r_d.cnt      = '0;
                    r_d.state    = ST_WBACK;
                end else begin
                    inv_en   = valid_v[r_q.way];
                    r_d.fset = fl_next_set;
                    r_d.way  = fl_next_way;
                    if (fl_last) r_d.state = ST_IDLE;
                end
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_busy  = (r_q.state != ST_IDLE);
    assign cpu_done  = r_q.done;
    assign cpu_rdata = r_q.rdata;

    // memory request held steady until acknowledged (R11)
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // completion is a single-cycle pulse (R11)
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // no memory traffic while idle (R11)
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_busy |-> !mem_req);

    // write-back transfers only happen under the write-back policy (R5, R12)
    assert_wb_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WBACK) |-> (mem_req && mem_we && pol_wb));

    // fill reads stay inside the requested line (R2)
    assert_fill_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FILL) |-> (!mem_we && mem_addr[31:SET_LSB] == r_q.addr[31:SET_LSB] && mem_addr[1:0] == 2'b00));

    // bypass transfer uses the exact request address (R1)
    assert_bypass_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BYPASS) |-> (mem_addr == r_q.addr && mem_we == r_q.we));

endmodule

// File: tb/sim_assoc_cache.sv
`timescale 1ns/1ps
module sim_assoc_cache;

    localparam int WAYS   = 2;
    localparam int SETS   = 4;
    localparam int WORDS  = 4;
    localparam int SET_SH = 4;
    localparam int TAG_SH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic [1:0]  wr_policy = 2'd0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        flush_req = 1'b0, inval_req = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    assoc_cache #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .wr_policy(wr_policy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .inval_req(inval_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem_m  [logic [31:0]];
    logic [31:0] shadow [logic [31:0]];
    logic [32:0] got_q[$];
    logic [32:0] exp_q[$];
    string       exp_tag;

    bit m_v [WAYS][SETS];
    bit m_d [WAYS][SETS];
    int m_t [WAYS][SETS];
    int m_p [SETS];

    function automatic logic [31:0] init_word(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
    endfunction

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : init_word(a);
    endfunction

    function automatic logic [31:0] arch_rd(logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : init_word(a);
    endfunction

    function automatic logic [31:0] line_addr(int t, int s, int i);
        return (32'(t) << TAG_SH) | (32'(s) << SET_SH) | (32'(i) << 2);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_traffic(input string req);
        bit          ok;
        logic [31:0] act, exp;
        ok  = (got_q.size() == exp_q.size());
        act = 32'(got_q.size());
        exp = 32'(exp_q.size());
        if (ok) begin
            foreach (exp_q[i]) begin
                if (ok && got_q[i] != exp_q[i]) begin
                    ok  = 1'b0;
                    act = got_q[i][31:0];
                    exp = exp_q[i][31:0];
                end
            end
        end
        chk(ok, req, "memory traffic", act, exp);
    endtask

    // reference model of one access: predicted transfers and state update
    task automatic model_access(input bit we, input logic [31:0] a);
        int s, t, hit, v;
        s = int'(a[5:4]);
        t = int'(a[31:6]);
        exp_q.delete();
        if (!cache_en || a >= 32'hF000_0000) begin
            exp_q.push_back({we, a});
            exp_tag = "R1";
            return;
        end
        hit = -1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_v[w][s] && m_t[w][s] == t) hit = w;
        if (hit >= 0) begin
            if (we) begin
                m_d[hit][s] = 1'b1;
                if (wr_policy != 2'd0) exp_q.push_back({1'b1, a});
                exp_tag = (wr_policy == 2'd0) ? "R5" : "R6";
            end else exp_tag = "R3";
            return;
        end
        if (we && wr_policy == 2'd2) begin
            exp_q.push_back({1'b1, a});
            exp_tag = "R7";
            return;
        end
        v = -1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!m_v[w][s]) v = w;
        if (v < 0) begin
            v = m_p[s];
            m_p[s] = (m_p[s] + 1) % WAYS;
        end
        exp_tag = "R2/R4/R8";
        if (m_v[v][s]) begin
            if (m_d[v][s] && wr_policy == 2'd0) begin
                for (int i = 0; i < WORDS; i++) exp_q.push_back({1'b1, line_addr(m_t[v][s], s, i)});
                exp_tag = "R2/R5/R8";
            end else exp_tag = "R2/R4/R8/R12";
        end
        for (int i = 0; i < WORDS; i++) exp_q.push_back({1'b0, line_addr(t, s, i)});
        m_v[v][s] = 1'b1;
        m_t[v][s] = t;
        m_d[v][s] = 1'b0;
        if (we) begin
            m_d[v][s] = 1'b1;
            if (wr_policy != 2'd0) exp_q.push_back({1'b1, a});
        end
    endtask

    task automatic do_access(input bit we, input logic [31:0] a, input logic [31:0] d);
        model_access(we, a);
        got_q.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_busy == 1'b1, "R11", "busy after accept", 32'(cpu_busy), 32'd1);
        while (!cpu_done) @(negedge clk);
        chk_traffic(exp_tag);
        if (!we) chk(cpu_rdata == arch_rd(a), exp_tag, "read data", cpu_rdata, arch_rd(a));
        else     shadow[a] = d;
    endtask

    task automatic do_flush();
        exp_q.delete();
        for (int w = WAYS - 1; w >= 0; w--)
            for (int s = 0; s < SETS; s++)
                if (m_v[w][s]) begin
                    if (m_d[w][s] && wr_policy == 2'd0)
                        for (int i = 0; i < WORDS; i++) exp_q.push_back({1'b1, line_addr(m_t[w][s], s, i)});
                    m_v[w][s] = 1'b0;
                    m_d[w][s] = 1'b0;
                end
        got_q.delete();
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        while (cpu_busy) @(negedge clk);
        chk_traffic("R9");
    endtask

    task automatic check_mem_matches(input string req);
        bit          ok = 1'b1;
        logic [31:0] act = '0, exp = '0;
        foreach (shadow[k]) begin
            if (ok && mem_rd(k) != shadow[k]) begin
                ok = 1'b0; act = mem_rd(k); exp = shadow[k];
            end
        end
        chk(ok, req, "memory image after flush", act, exp);
    endtask

    task automatic do_inval();
        got_q.delete();
        inval_req = 1'b1;
        @(negedge clk);
        inval_req = 1'b0;
        chk(got_q.size() == 0 && !cpu_busy, "R10", "invalidate traffic", 32'(got_q.size()), 32'd0);
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
                m_v[w][s] = 1'b0;
                m_d[w][s] = 1'b0;
            end
        foreach (shadow[k]) shadow[k] = mem_rd(k);
    endtask

    function automatic logic [31:0] rand_addr();
        if ($urandom_range(9, 0) == 0) return 32'hF000_0000 + 32'($urandom_range(15, 0)) * 4;
        return 32'h0001_0000 | line_addr($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0));
    endfunction

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            bit we;
            we = ($urandom_range(2, 0) == 0);
            do_access(we, rand_addr(), $urandom());
        end
    endtask

    // memory responder: 0..2 wait cycles, one-cycle acknowledge
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (dly == 0) begin
                    got_q.push_back({mem_we, mem_addr});
                    if (mem_we) mem_m[mem_addr] = mem_wdata;
                    else        mem_rdata = mem_rd(mem_addr);
                    mem_ack = 1'b1;
                    dly = $urandom_range(2, 0);
                end else dly--;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd7719));
        for (int s = 0; s < SETS; s++) m_p[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_busy && !cpu_done && !mem_req, "R11", "reset state",
            {29'd0, cpu_busy, cpu_done, mem_req}, 32'd0);

        // write-back: directed line fill, hit, then eviction of a dirty line
        wr_policy = 2'd0;
        a = 32'h0001_0028;
        do_access(1'b0, a, 32'h0);
        do_access(1'b0, a + 4, 32'h0);
        do_access(1'b1, a, 32'hDEAD_BEEF);
        do_access(1'b1, a + 32'h40, 32'h1111_2222);
        do_access(1'b0, a + 32'h80, 32'h0);
        do_access(1'b0, a + 32'hC0, 32'h0);
        do_access(1'b0, a, 32'h0);
        random_run(300);
        do_flush();
        check_mem_matches("R5/R9");

        // invalidate discards dirty data
        do_access(1'b1, a, 32'hCAFE_F00D);
        do_inval();
        do_access(1'b0, a, 32'h0);
        chk(cpu_rdata != 32'hCAFE_F00D, "R10", "dirty data dropped", cpu_rdata, mem_rd(a));
        do_flush();

        // write-through with allocation
        wr_policy = 2'd1;
        do_access(1'b1, 32'h0001_0104, 32'h5555_AAAA);
        random_run(300);
        do_flush();
        check_mem_matches("R6/R9");

        // write-through without allocation
        wr_policy = 2'd2;
        do_access(1'b1, 32'h0001_0208, 32'h1234_5678);
        do_access(1'b0, 32'h0001_0208, 32'h0);
        random_run(300);
        do_flush();
        check_mem_matches("R7/R9");

        // cache disabled
        cache_en = 1'b0;
        wr_policy = 2'd0;
        random_run(60);
        do_access(1'b0, 32'hFFFF_FFFC, 32'h0);
        cache_en = 1'b1;
        do_access(1'b1, 32'hF000_0010, 32'h0BAD_F00D);
        do_access(1'b0, 32'hF000_0010, 32'h0);
        do_flush();
        check_mem_matches("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule